// File: doc/BRIEF.md
# March-Sequence Memory Self-Test Controller

This block is a self-test sequencer for a RAM that is one bit wide and `CELLS` cells deep. Once it is started, it runs a fixed test made of six march elements. Each element performs its whole list of operations on one cell before it moves to the next cell. An element covers every cell before the next element begins. Ascending order runs from cell 0 to cell `CELLS-1`. Descending order is exactly the reverse.

The controller issues one RAM operation per clock. The RAM returns read data one cycle after the read is issued. The expected value of each read is carried through a one-stage pipeline and compared in that cycle. The first mismatch raises `fail` and records the cell address, the element number (0 to 5) and the operation index inside the element (0 to 4). The test still runs to the end, and then `done` is raised.

The sequencer has four states:
- `ST_IDLE`: waits after reset. `ST_IDLE -> ST_RUN` on `start`.
- `ST_RUN`: issues operations. `ST_RUN -> ST_DRAIN` after the final operation of element 5.
- `ST_DRAIN`: one cycle in which the last read is compared. `ST_DRAIN -> ST_DONE` always.
- `ST_DONE`: holds `done` and the results. `ST_DONE -> ST_RUN` on a new `start`.

Top module: `march_bist`

## Requirements
- R1: After reset, `done`, `fail` and `mem_en` are 0, and no RAM operation is issued until `start` is seen high in `ST_IDLE` or `ST_DONE`.
- R2: Element 0 writes 1 (`mem_we`=1, `mem_wdata`=1) to every cell in ascending address order.
- R3: Element 1 runs in descending order and performs, per cell: read, write 0, read, write 0, read. The reads expect 1, 0 and 0.
- R4: Element 2 runs in descending order and performs, per cell: read, write 1, read, write 1, read. The reads expect 0, 1 and 1.
- R5: Elements 3 and 4 repeat the operation lists of elements 1 and 2 in ascending order.
- R6: Element 5 reads every cell in ascending order and expects 1, the value element 4 leaves behind.
- R7: Operations are issued on consecutive clocks, `22*CELLS` in total, and `mem_we` is only high together with `mem_en`. `done` rises `22*CELLS+1` clocks after the clock that samples `start`. It stays high with no RAM activity until the next `start`.
- R8: Read data on `mem_rdata` is compared in the cycle after the read is issued, and a mismatch sets `fail`.
- R9: Only the first mismatch is recorded. `fail_addr` holds its cell, `fail_elem` its element number (0..5) and `fail_op` its operation index (0..4). Later mismatches change nothing.
- R10: A `start` accepted in `ST_DONE` clears `fail` and reruns the complete test.
- R11: With a fault-free RAM, `fail` is 0 when `done` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test run (accepted in idle or done) |
| mem_en | output | 1 | RAM operation enable |
| mem_we | output | 1 | RAM write enable (read when 0) |
| mem_addr | output | AW | RAM cell address |
| mem_wdata | output | 1 | RAM write data |
| mem_rdata | input | 1 | RAM read data, valid one cycle after a read |
| done | output | 1 | Test complete |
| fail | output | 1 | At least one read mismatched |
| fail_addr | output | AW | Cell of the first mismatch |
| fail_elem | output | 3 | Element number of the first mismatch |
| fail_op | output | 3 | Operation index of the first mismatch |

## Verification
A read comparison and a state change can fall in the same cycle in two places. The last read of an element is compared while the first operation of the next element is issued. The very last read of element 5 is compared in the `ST_DRAIN` cycle, in the same clock in which the sequencer commits to `ST_DONE`.

The bench provokes both cases with a behavioural RAM that has injected faults. A cell flipped at a chosen operation count makes the final read of cell `CELLS-1` in element 5 mismatch. The bench then requires `fail` to be already set when `done` first rises, with address, element and operation all recorded. Faults at both ends of the address range, and aggressor/victim pairs in both orders, place the first mismatch on element boundaries. Each recorded location is compared with a value worked out by hand from the march order.

// File: rtl/march_pkg.sv
package march_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } mstate_t;

    typedef struct packed {
        logic wr;      // 1 = write, 0 = read
        logic bitval;  // data written or value expected
    } mop_t;

    localparam int ELEMS = 6;
    localparam int EW    = 3;
    localparam int OW    = 3;
    localparam logic [EW-1:0] LAST_ELEM = EW'(ELEMS - 1);

    // Index of the final operation inside element e.
    function automatic logic [OW-1:0] last_op(input logic [EW-1:0] e);
        return (e == '0 || e == LAST_ELEM) ? OW'(0) : OW'(4);
    endfunction

    // Elements 1 and 2 walk downward, all others upward.
    function automatic logic descending(input logic [EW-1:0] e);
        return (e == EW'(1)) || (e == EW'(2));
    endfunction

    // Operation i of element e.
    function automatic mop_t op_at(input logic [EW-1:0] e, input logic [OW-1:0] i);
        mop_t o;
        logic b;
        b = (e == EW'(1)) || (e == EW'(3));   // value expected by the opening read
        if (e == '0)
            o = '{wr: 1'b1, bitval: 1'b1};
        else if (e == LAST_ELEM)
            o = '{wr: 1'b0, bitval: 1'b1};
        else if (i == '0)
            o = '{wr: 1'b0, bitval: b};
        else
            o = '{wr: i[0], bitval: ~b};
        return o;
    endfunction

endpackage

// File: rtl/march_addr_gen.sv
module march_addr_gen #(
    parameter int CELLS = 16,
    localparam int AW = (CELLS > 1) ? $clog2(CELLS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          load_desc,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          at_end
);
    localparam logic [AW-1:0] TOP = AW'(CELLS - 1);

    logic dir_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr  <= '0;
            dir_q <= 1'b0;
        end else if (load) begin
            addr  <= load_desc ? TOP : '0;
            dir_q <= load_desc;
        end else if (step) begin
            addr  <= dir_q ? addr - 1'b1 : addr + 1'b1;
        end
    end

    assign at_end = dir_q ? (addr == '0) : (addr == TOP);

endmodule

// File: rtl/march_step_ctr.sv
module march_step_ctr
    import march_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          advance,
    input  logic          cell_end,
    output logic [EW-1:0] elem,
    output logic [OW-1:0] opi,
    output logic          op_end,
    output logic          seq_end
);
    assign op_end  = (opi == last_op(elem));
    assign seq_end = op_end && cell_end && (elem == LAST_ELEM);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            elem <= '0;
            opi  <= '0;
        end else if (advance) begin
            if (op_end) begin
                opi <= '0;
                if (cell_end && !seq_end)
                    elem <= elem + 1'b1;
            end else begin
                opi <= opi + 1'b1;
            end
        end
    end

endmodule

// File: rtl/march_compare.sv
module march_compare
    import march_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          rd_issue,
    input  logic          rd_exp,
    input  logic [AW-1:0] rd_addr,
    input  logic [EW-1:0] rd_elem,
    input  logic [OW-1:0] rd_op,
    input  logic          rdata,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [EW-1:0] fail_elem,
    output logic [OW-1:0] fail_op
);
    logic          pv;
    logic          pe;
    logic [AW-1:0] pa;
    logic [EW-1:0] pel;
    logic [OW-1:0] po;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pv        <= 1'b0;
            pe        <= 1'b0;
            pa        <= '0;
            pel       <= '0;
            po        <= '0;
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_elem <= '0;
            fail_op   <= '0;
        end else begin
            pv  <= rd_issue;
            pe  <= rd_exp;
            pa  <= rd_addr;
            pel <= rd_elem;
            po  <= rd_op;
            if (pv && (rdata != pe) && !fail) begin
                fail      <= 1'b1;
                fail_addr <= pa;
                fail_elem <= pel;
                fail_op   <= po;
            end
        end
    end

endmodule

// File: rtl/march_bist.sv
module march_bist
    import march_pkg::*;
#(
    parameter int CELLS = 16,
    localparam int AW = (CELLS > 1) ? $clog2(CELLS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic          mem_wdata,
    input  logic          mem_rdata,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [2:0]    fail_elem,
    output logic [2:0]    fail_op
);
    mstate_t       state, state_nx;
    logic          accept, advance;
    logic [EW-1:0] elem;
    logic [OW-1:0] opi;
    logic          op_end, seq_end, cell_end;
    logic [AW-1:0] addr;
    logic          ld, ld_desc, stp;
    mop_t          op;

    assign accept  = start && (state == ST_IDLE || state == ST_DONE);
    assign advance = (state == ST_RUN);
    assign op      = op_at(elem, opi);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)   state_nx = ST_RUN;
            ST_RUN:   if (seq_end) state_nx = ST_DRAIN;
            ST_DRAIN:              state_nx = ST_DONE;
            ST_DONE:  if (start)   state_nx = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE, ST_DRAIN: ;
            ST_RUN: begin
                mem_en    = 1'b1;
                mem_we    = op.wr;
                mem_wdata = op.bitval;
            end
            ST_DONE: done = 1'b1;
        endcase
    end
    assign mem_addr = addr;

    // Address sequencing across element boundaries
    assign ld      = accept || (advance && op_end && cell_end && !seq_end);
    assign ld_desc = accept ? descending('0) : descending(elem + 1'b1);
    assign stp     = advance && op_end && !cell_end;

    march_step_ctr u_steps (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .advance  (advance),
        .cell_end (cell_end),
        .elem     (elem),
        .opi      (opi),
        .op_end   (op_end),
        .seq_end  (seq_end)
    );

    march_addr_gen #(.CELLS(CELLS)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld),
        .load_desc (ld_desc),
        .step      (stp),
        .addr      (addr),
        .at_end    (cell_end)
    );

    march_compare #(.AW(AW)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .rd_issue  (advance && !op.wr),
        .rd_exp    (op.bitval),
        .rd_addr   (addr),
        .rd_elem   (elem),
        .rd_op     (opi),
        .rdata     (mem_rdata),
        .fail      (fail),
        .fail_addr (fail_addr),
        .fail_elem (fail_elem),
        .fail_op   (fail_op)
    );

endmodule

// File: rtl/march_bist_chk.sv
module march_bist_chk #(
    parameter int CELLS = 16,
    localparam int AW = (CELLS > 1) ? $clog2(CELLS) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          mem_en,
    input logic          mem_we,
    input logic          done,
    input logic          fail,
    input logic [AW-1:0] fail_addr,
    input logic [2:0]    fail_elem,
    input logic [2:0]    fail_op
);
    // R7
    write_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

    // R7
    quiet_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_en);

    // R7
    drain_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !$past(mem_en));

    // R8
    fail_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> $past(mem_en && !mem_we, 2));

    // R9
    first_fail_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> (fail && $stable(fail_addr) && $stable(fail_elem) && $stable(fail_op)));

endmodule

bind march_bist march_bist_chk #(.CELLS(CELLS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .done      (done),
    .fail      (fail),
    .fail_addr (fail_addr),
    .fail_elem (fail_elem),
    .fail_op   (fail_op)
);

// File: tb/tb_march_bist.sv
module tb_march_bist;
    localparam int CELLS = 16;
    localparam int AW    = 4;
    localparam int TOTAL = 22 * CELLS;
    localparam int NV    = 13;

    localparam int K_NONE = 0;
    localparam int K_SA0  = 1;  // cells fa and fb stuck at 0
    localparam int K_SA1  = 2;  // cell fa stuck at 1
    localparam int K_CFID = 3;  // write 1->0 on fa forces fb to 1
    localparam int K_DRD  = 4;  // reading 1 from fa returns 1 but clears it
    localparam int K_FLIP = 5;  // fa inverted once after fb operations

    typedef struct packed {
        int kind; int fa; int fb;
        int efail; int eaddr; int eelem; int eop;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{K_NONE,  0,  0,     0,  0, 0, 0},
        '{K_SA0,   5,  5,     1,  5, 1, 0},
        '{K_SA1,   9,  9,     1,  9, 1, 2},
        '{K_SA0,  12,  5,     1, 12, 1, 0},
        '{K_NONE,  0,  0,     0,  0, 0, 0},
        '{K_SA0,   0,  0,     1,  0, 1, 0},
        '{K_SA1,  15, 15,     1, 15, 1, 2},
        '{K_CFID,  3,  7,     1,  7, 2, 0},
        '{K_CFID,  7,  3,     1,  3, 4, 0},
        '{K_DRD,  10, 10,     1, 10, 3, 0},
        '{K_FLIP, 12, 21*CELLS+4, 1, 12, 5, 0},
        '{K_FLIP, 15, 21*CELLS,   1, 15, 5, 0},
        '{K_NONE,  0,  0,     0,  0, 0, 0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mem_en, mem_we, mem_wdata, done, fail;
    logic          mem_rdata = 1'b0;
    logic [AW-1:0] mem_addr, fail_addr;
    logic [2:0]    fail_elem, fail_op;

    always #4 clk = ~clk;

    march_bist #(.CELLS(CELLS)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .fail(fail), .fail_addr(fail_addr),
        .fail_elem(fail_elem), .fail_op(fail_op)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural RAM with fault injection
    logic mem [CELLS];
    bit   stk [CELLS];
    logic stv [CELLS];
    int   f_kind = K_NONE, f_a = 0, f_b = 0;
    int   op_cnt = 0;

    always @(posedge clk) begin
        if (f_kind == K_FLIP && op_cnt == f_b) mem[f_a] = ~mem[f_a];
        if (mem_en) begin
            if (mem_we) begin
                if (f_kind == K_CFID && int'(mem_addr) == f_a && !mem_wdata && mem[f_a])
                    mem[f_b] = 1'b1;
                mem[mem_addr] = stk[mem_addr] ? stv[mem_addr] : mem_wdata;
            end else begin
                mem_rdata <= mem[mem_addr];
                if (f_kind == K_DRD && int'(mem_addr) == f_a && mem[f_a])
                    mem[f_a] = 1'b0;
            end
            op_cnt++;
        end
    end

    // Operation log sampled between edges
    bit   log_on = 1'b0;
    int   log_n = 0;
    int   lg_addr [TOTAL];
    logic lg_we   [TOTAL];
    logic lg_wd   [TOTAL];

    always @(negedge clk) begin
        if (log_on && mem_en) begin
            if (log_n < TOTAL) begin
                lg_addr[log_n] = int'(mem_addr);
                lg_we[log_n]   = mem_we;
                lg_wd[log_n]   = mem_wdata;
            end
            log_n++;
        end
    end

    task automatic setup_ram(input int kind, input int fa, input int fb);
        for (int c = 0; c < CELLS; c++) begin
            mem[c] = 1'b0; stk[c] = 1'b0; stv[c] = 1'b0;
        end
        f_kind = kind; f_a = fa; f_b = fb;
        if (kind == K_SA0) begin
            stk[fa] = 1'b1; stk[fb] = 1'b1;
        end
        if (kind == K_SA1) begin
            stk[fa] = 1'b1; stv[fa] = 1'b1; mem[fa] = 1'b1;
        end
        op_cnt = 0;
    endtask

    // Pulse start, return clocks from the sampling edge to done
    task automatic run_once(output int cyc);
        @(negedge clk);
        log_n = 0;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 4 * TOTAL) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
    endtask

    // Expected op stream built from the requirement text
    task automatic check_stream();
        int k = 0;
        for (int e = 0; e < 6; e++) begin
            int bad = 0;
            int len = (e == 0 || e == 5) ? 1 : 5;
            bit dsc = (e == 1 || e == 2);
            bit b = (e == 1 || e == 3);
            for (int c = 0; c < CELLS; c++) begin
                int a = dsc ? CELLS - 1 - c : c;
                for (int i = 0; i < len; i++) begin
                    bit w; bit d;
                    if (e == 0) begin w = 1; d = 1; end
                    else if (e == 5) begin w = 0; d = 0; end
                    else if (i == 0) begin w = 0; d = 0; end
                    else begin w = (i % 2 == 1); d = ~b; end
                    if (lg_addr[k] != a || lg_we[k] != w || (w && lg_wd[k] != d)) bad++;
                    k++;
                end
            end
            case (e)
                0: chk("R2 element 0 write-1 ascending mismatches", bad, 0);
                1: chk("R3 element 1 descending mismatches", bad, 0);
                2: chk("R4 element 2 descending mismatches", bad, 0);
                3: chk("R5 element 3 ascending mismatches", bad, 0);
                4: chk("R5 element 4 ascending mismatches", bad, 0);
                default: chk("R6 element 5 read-out mismatches", bad, 0);
            endcase
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int cyc;
        setup_ram(K_NONE, 0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and idle without start
        chk("R1 done after reset", int'(done), 0);
        chk("R1 fail after reset", int'(fail), 0);
        chk("R1 mem_en after reset", int'(mem_en), 0);
        repeat (5) @(negedge clk);
        chk("R1 mem_en while idle", int'(mem_en), 0);

        log_on = 1'b1;
        for (int v = 0; v < NV; v++) begin
            setup_ram(VECS[v].kind, VECS[v].fa, VECS[v].fb);
            run_once(cyc);
            // R7: done timing and op count
            chk("R7 clocks from start to done", cyc, TOTAL + 1);
            chk("R7 operations issued", log_n, TOTAL);
            if (VECS[v].efail == 0) begin
                // R11 R10
                chk("R11 R10 fail with good RAM", int'(fail), 0);
            end else begin
                // R8 R9
                chk("R8 fail flag", int'(fail), 1);
                chk("R9 fail_addr", int'(fail_addr), VECS[v].eaddr);
                chk("R9 fail_elem", int'(fail_elem), VECS[v].eelem);
                chk("R9 fail_op", int'(fail_op), VECS[v].eop);
            end
            if (v == 0) begin
                check_stream();
                repeat (3) @(negedge clk);
                chk("R7 done held", int'(done), 1);
                chk("R7 no ops while done", int'(mem_en), 0);
            end
        end
        log_on = 1'b0;

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule